// File: doc/BRIEF.md
# Cartridge Memory Bank Controller

This block sits between an 8-bit processor bus with a 16-bit address and a cartridge's ROM and battery-backed RAM. The ROM address range cannot be written, so the controller treats processor writes into it as writes to three control registers. These are a RAM unlock gate, a switchable ROM bank number and a RAM bank number. From those registers and the current bus address it forms the physical ROM and RAM addresses, the RAM chip enable and write enable, and the byte returned to the processor.

None of the block's interfaces carries a stream, so it has no valid/ready handshake. Every pin is a plain control or data signal. Register writes take effect on a clock edge. The address outputs, the enables and the read data are combinational from the bus inputs and the registers as they stand in that cycle. The lowest 16 KiB of ROM is always mapped at the bottom of the address space. The window at 0x4000–0x7FFF shows the selected ROM bank. The window at 0xA000–0xBFFF shows the selected 8 KiB RAM bank, but only while RAM is unlocked.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A write with the address in 0x0000–0x1FFF unlocks RAM when the data byte is exactly 0x0A, and locks RAM for every other data value.
- R2: A write with the address in 0x2000–0x3FFF loads the ROM bank register with data bits 6:0. A data byte of 0x00 loads bank 1 instead. A data byte of 0x80 loads bank 0, because only the whole byte being zero forces bank 1.
- R3: A write with the address in 0x4000–0x5FFF loads the RAM bank register with data bits 1:0.
- R4: For addresses 0x0000–0x3FFF, rom_addr equals address bits 13:0 and its upper 7 bits are zero. rom_ce is high exactly when cpu_rd is high and address bit 15 is 0.
- R5: For every address outside 0x0000–0x3FFF, rom_addr is {rom bank[6:0], address[13:0]}, which is rom bank × 0x4000 + (address − 0x4000) in the 0x4000–0x7FFF window.
- R6: ram_addr is always {ram bank[1:0], address[12:0]}. ram_ce is high exactly when the address is in 0xA000–0xBFFF, RAM is unlocked, and cpu_rd or cpu_wr is high.
- R7: cpu_rdata shows rom_rdata for addresses below 0x8000. It shows ram_rdata in 0xA000–0xBFFF while RAM is unlocked. It is 0xFF in that window while RAM is locked, and 0xFF at all other addresses.
- R8: While rst_n is low, the registers take ROM bank 1, RAM bank 0 and RAM locked.
- R9: ram_we is high only when cpu_wr is high, the address is in 0xA000–0xBFFF and RAM is unlocked. A write to the locked window never raises it.
- R10: A write with the address in 0x6000–0x7FFF changes no register. Reads made afterwards show the same ROM bank, RAM bank and lock state as before the write.
- R11: A register write is sampled on the rising clock edge while cpu_wr is high. Its effect shows on the outputs in the cycle after that edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor bus address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_wr | input | 1 | Write strobe, one bus write per cycle high |
| cpu_rd | input | 1 | Read strobe |
| rom_rdata | input | 8 | Byte returned by the ROM |
| ram_rdata | input | 8 | Byte returned by the RAM |
| rom_addr | output | 21 | Physical ROM byte address |
| rom_ce | output | 1 | ROM chip enable |
| ram_addr | output | 15 | Physical RAM byte address |
| ram_ce | output | 1 | RAM chip enable |
| ram_we | output | 1 | RAM write enable |
| cpu_rdata | output | 8 | Byte returned to the processor |

## Verification
Every address output, enable and read byte is due in the same cycle the bus inputs are presented, with no register in the path. A register write is due one clock edge later. The bench drives each bus cycle at the falling edge and compares every output against its behavioural model a little after that. It then advances the model on the following rising edge, the same edge the design samples. A write is therefore seen at the next comparison and at none before it.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  // Which control register a write in the ROM space targets.
  typedef enum logic [1:0] {
    TGT_RAM_GATE = 2'd0,
    TGT_ROM_SEL  = 2'd1,
    TGT_RAM_SEL  = 2'd2,
    TGT_NONE     = 2'd3
  } wr_tgt_e;

  // Address window of a bus cycle.
  typedef enum logic [1:0] {
    WIN_ROM_FIXED = 2'd0,
    WIN_ROM_BANK  = 2'd1,
    WIN_RAM       = 2'd2,
    WIN_OPEN      = 2'd3
  } win_e;

  function automatic wr_tgt_e tgt_of(input logic [2:0] top3);
    if (top3[2]) return TGT_NONE;
    case (top3[1:0])
      2'd0:    return TGT_RAM_GATE;
      2'd1:    return TGT_ROM_SEL;
      2'd2:    return TGT_RAM_SEL;
      default: return TGT_NONE;
    endcase
  endfunction

  function automatic win_e win_of(input logic [2:0] top3);
    if (!top3[2])             return top3[1] ? WIN_ROM_BANK : WIN_ROM_FIXED;
    else if (top3 == 3'b101)  return WIN_RAM;
    else                      return WIN_OPEN;
  endfunction

endpackage

// File: rtl/cbc_regs.sv
module cbc_regs
  import cbc_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 2,
  parameter logic [7:0] UNLOCK_KEY = 8'h0A
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [2:0]            addr_top,
  input  logic [7:0]            wdata,
  output logic                  ram_en,
  output logic [ROM_BANK_W-1:0] rom_bank,
  output logic [RAM_BANK_W-1:0] ram_bank
);

  wr_tgt_e tgt;
  logic [ROM_BANK_W-1:0] rom_bank_nxt;

  assign tgt = tgt_of(addr_top);
  // Only a whole zero byte is promoted to bank 1.
  assign rom_bank_nxt = (wdata == 8'h00) ? ROM_BANK_W'(1) : wdata[ROM_BANK_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_en   <= 1'b0;
      rom_bank <= ROM_BANK_W'(1);
      ram_bank <= '0;
    end else if (wr) begin
      case (tgt)
        TGT_RAM_GATE: ram_en   <= (wdata == UNLOCK_KEY);
        TGT_ROM_SEL:  rom_bank <= rom_bank_nxt;
        TGT_RAM_SEL:  ram_bank <= wdata[RAM_BANK_W-1:0];
        default:      ;
      endcase
    end
  end

endmodule

// File: rtl/cbc_map.sv
module cbc_map
  import cbc_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 2,
  parameter int ROM_OFS_W  = 14,
  parameter int RAM_OFS_W  = 13,
  localparam int ROM_AW    = ROM_BANK_W + ROM_OFS_W,
  localparam int RAM_AW    = RAM_BANK_W + RAM_OFS_W
) (
  input  logic [15:0]           addr,
  input  logic                  rd,
  input  logic                  wr,
  input  logic                  ram_en,
  input  logic [ROM_BANK_W-1:0] rom_bank,
  input  logic [RAM_BANK_W-1:0] ram_bank,
  output win_e                  win,
  output logic [ROM_AW-1:0]     rom_addr,
  output logic                  rom_ce,
  output logic [RAM_AW-1:0]     ram_addr,
  output logic                  ram_ce,
  output logic                  ram_we
);

  logic ram_open;

  assign win      = win_of(addr[15:13]);
  assign ram_open = (win == WIN_RAM) && ram_en;

  always_comb begin
    if (win == WIN_ROM_FIXED) rom_addr = {{ROM_BANK_W{1'b0}}, addr[ROM_OFS_W-1:0]};
    else                      rom_addr = {rom_bank, addr[ROM_OFS_W-1:0]};
  end

  assign rom_ce   = rd && !addr[15];
  assign ram_addr = {ram_bank, addr[RAM_OFS_W-1:0]};
  assign ram_ce   = ram_open && (rd || wr);
  assign ram_we   = ram_open && wr;

endmodule

// File: rtl/cbc_rdmux.sv
module cbc_rdmux
  import cbc_pkg::*;
#(
  parameter logic [7:0] OPEN_BUS = 8'hFF
) (
  input  win_e       win,
  input  logic       ram_en,
  input  logic [7:0] rom_rdata,
  input  logic [7:0] ram_rdata,
  output logic [7:0] cpu_rdata
);

  always_comb begin
    case (win)
      WIN_ROM_FIXED, WIN_ROM_BANK: cpu_rdata = rom_rdata;
      WIN_RAM:  cpu_rdata = ram_en ? ram_rdata : OPEN_BUS;
      default:  cpu_rdata = OPEN_BUS;
    endcase
  end

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 2,
  parameter int ROM_OFS_W  = 14,
  parameter int RAM_OFS_W  = 13,
  parameter logic [7:0] UNLOCK_KEY = 8'h0A,
  parameter logic [7:0] OPEN_BUS   = 8'hFF,
  localparam int ROM_AW = ROM_BANK_W + ROM_OFS_W,
  localparam int RAM_AW = RAM_BANK_W + RAM_OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [7:0]        rom_rdata,
  input  logic [7:0]        ram_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_ce,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_ce,
  output logic              ram_we,
  output logic [7:0]        cpu_rdata
);

  logic                  ram_en;
  logic [ROM_BANK_W-1:0] rom_bank;
  logic [RAM_BANK_W-1:0] ram_bank;
  win_e                  win;

  cbc_regs #(
    .ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W), .UNLOCK_KEY(UNLOCK_KEY)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cpu_wr), .addr_top(cpu_addr[15:13]),
    .wdata(cpu_wdata), .ram_en(ram_en), .rom_bank(rom_bank), .ram_bank(ram_bank)
  );

  cbc_map #(
    .ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W),
    .ROM_OFS_W(ROM_OFS_W), .RAM_OFS_W(RAM_OFS_W)
  ) u_map (
    .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr), .ram_en(ram_en),
    .rom_bank(rom_bank), .ram_bank(ram_bank), .win(win),
    .rom_addr(rom_addr), .rom_ce(rom_ce), .ram_addr(ram_addr),
    .ram_ce(ram_ce), .ram_we(ram_we)
  );

  cbc_rdmux #(.OPEN_BUS(OPEN_BUS)) u_rdmux (
    .win(win), .ram_en(ram_en), .rom_rdata(rom_rdata),
    .ram_rdata(ram_rdata), .cpu_rdata(cpu_rdata)
  );

endmodule

// File: rtl/cbc_checker.sv
module cbc_checker #(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 2,
  parameter logic [7:0] UNLOCK_KEY = 8'h0A
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [15:0]           cpu_addr,
  input logic [7:0]            cpu_wdata,
  input logic                  cpu_wr,
  input logic                  cpu_rd,
  input logic                  ram_en,
  input logic [ROM_BANK_W-1:0] rom_bank,
  input logic [RAM_BANK_W-1:0] ram_bank,
  input logic                  ram_ce,
  input logic                  ram_we,
  input logic [7:0]            cpu_rdata
);

  logic in_gate, in_romsel, in_ramsel, in_nop, in_ramwin;
  assign in_gate   = cpu_addr[15:13] == 3'b000;
  assign in_romsel = cpu_addr[15:13] == 3'b001;
  assign in_ramsel = cpu_addr[15:13] == 3'b010;
  assign in_nop    = cpu_addr[15:13] == 3'b011;
  assign in_ramwin = cpu_addr[15:13] == 3'b101;

  assert_unlock_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && in_gate |=> ram_en == ($past(cpu_wdata) == UNLOCK_KEY));

  assert_rom_bank_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && in_romsel |=> rom_bank == (($past(cpu_wdata) == 8'h00) ?
      ROM_BANK_W'(1) : $past(cpu_wdata[ROM_BANK_W-1:0])));

  assert_ram_bank_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && in_ramsel |=> ram_bank == $past(cpu_wdata[RAM_BANK_W-1:0]));

  assert_locked_read_ff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && in_ramwin && !ram_en |-> cpu_rdata == 8'hFF);

  assert_reset_values_R8: assert property (@(posedge clk)
    !rst_n |=> (!ram_en && rom_bank == ROM_BANK_W'(1) && ram_bank == '0));

  assert_we_needs_unlock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_en && ram_ce && cpu_wr && in_ramwin));

  assert_nop_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && in_nop |=> ($stable(ram_en) && $stable(rom_bank) && $stable(ram_bank)));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> ($stable(ram_en) && $stable(rom_bank) && $stable(ram_bank)));

endmodule

bind cart_bank_ctrl cbc_checker #(
  .ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W), .UNLOCK_KEY(UNLOCK_KEY)
) u_cbc_checker (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .ram_en(ram_en), .rom_bank(rom_bank),
  .ram_bank(ram_bank), .ram_ce(ram_ce), .ram_we(ram_we), .cpu_rdata(cpu_rdata)
);

// File: tb/tb_cart_bank_ctrl.sv
module tb_cart_bank_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] a = '0;
  logic [7:0]  wd = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  romd, ramd;
  logic [20:0] rom_addr;
  logic [14:0] ram_addr;
  logic        rom_ce, ram_ce, ram_we;
  logic [7:0]  cpu_rdata;

  assign romd = a[7:0] ^ 8'h5A;
  assign ramd = a[7:0] ^ 8'hC3;

  cart_bank_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(a), .cpu_wdata(wd), .cpu_wr(wr),
    .cpu_rd(rd), .rom_rdata(romd), .ram_rdata(ramd), .rom_addr(rom_addr),
    .rom_ce(rom_ce), .ram_addr(ram_addr), .ram_ce(ram_ce), .ram_we(ram_we),
    .cpu_rdata(cpu_rdata)
  );

  // Behavioural reference state
  int m_en = 0, m_rb = 1, m_xb = 0;
  int errs = 0, checks = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, int ad, int d, bit w, bit r);
    int e_rom, e_rd;
    bit win;
    @(negedge clk);
    a = 16'(ad); wd = 8'(d); wr = w; rd = r;
    #1;
    win   = (ad >= 'hA000) && (ad < 'hC000);
    e_rom = (ad < 'h4000) ? (ad & 'h3FFF) : ((m_rb << 14) | (ad & 'h3FFF));
    if (ad < 'h8000)         e_rd = (ad & 'hFF) ^ 'h5A;
    else if (win && m_en!=0) e_rd = (ad & 'hFF) ^ 'hC3;
    else                     e_rd = 'hFF;
    chk(req, (ad < 'h4000) ? "R4 rom_addr" : "R5 rom_addr", int'(rom_addr), e_rom);
    chk(req, "R4 rom_ce", int'(rom_ce), int'(r && ad < 'h8000));
    chk(req, "R6 ram_addr", int'(ram_addr), (m_xb << 13) | (ad & 'h1FFF));
    chk(req, "R6 ram_ce", int'(ram_ce), int'(win && m_en != 0 && (r || w)));
    chk(req, "R9 ram_we", int'(ram_we), int'(win && m_en != 0 && w));
    chk(req, "R7 cpu_rdata", int'(cpu_rdata), e_rd);
    @(posedge clk);
    if (!rst_n) begin
      m_en = 0; m_rb = 1; m_xb = 0;
    end else if (w) begin
      if (ad < 'h2000)      m_en = (d == 'h0A) ? 1 : 0;
      else if (ad < 'h4000) m_rb = (d == 0) ? 1 : (d & 'h7F);
      else if (ad < 'h6000) m_xb = d & 3;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int lfsr;
    int pick;
    step("R8 reset", 'h4123, 0, 0, 1);
    step("R8 reset", 'hA001, 0, 0, 1);
    @(negedge clk); rst_n = 1'b1;
    step("R4 fixed bank", 'h0123, 0, 0, 1);
    step("R5 bank1 after reset R8", 'h4567, 0, 0, 1);
    step("R7 locked read", 'hA010, 0, 0, 1);
    step("R9 locked write", 'hA010, 'h33, 1, 0);
    step("R1 unlock 0x0A", 'h1000, 'h0A, 1, 0);
    step("R11 unlocked next cycle", 'hA010, 0, 0, 1);
    step("R9 unlocked write", 'hB234, 'h77, 1, 0);
    step("R2 zero forces bank1", 'h2000, 'h00, 1, 0);
    step("R2 read bank1", 'h7FFF, 0, 0, 1);
    step("R2 write 0x85", 'h3FFF, 'h85, 1, 0);
    step("R11 bank5 next cycle", 'h4000, 0, 0, 1);
    step("R2 write 0x80 gives bank0", 'h2100, 'h80, 1, 0);
    step("R2 bank0 read", 'h4001, 0, 0, 1);
    step("R2 write 0xFF", 'h2000, 'hFF, 1, 0);
    step("R5 bank7F read", 'h7ABC, 0, 0, 1);
    step("R3 ram bank 0x07", 'h4000, 'h07, 1, 0);
    step("R3 ram bank3 read", 'hBFFF, 0, 0, 1);
    step("R10 ignored write", 'h6000, 'h55, 1, 0);
    step("R10 rom bank kept", 'h4001, 0, 0, 1);
    step("R10 ram kept", 'hA000, 0, 0, 1);
    step("R10 ignored write", 'h7FFF, 'h0B, 1, 0);
    step("R10 ram still unlocked", 'hA100, 0, 0, 1);
    step("R1 lock 0x0B", 'h0000, 'h0B, 1, 0);
    step("R1 locked read", 'hA000, 0, 0, 1);
    step("R1 unlock again", 'h1FFF, 'h0A, 1, 0);
    step("R7 open address", 'hC000, 0, 0, 1);
    step("R7 open address", 'h8123, 0, 0, 1);
    step("R6 idle bus", 'hA222, 0, 0, 0);
    lfsr = 'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = ((lfsr >> 1) ^ ((lfsr & 1) != 0 ? 'hB400 : 0)) & 'hFFFF;
      pick = lfsr & 7;
      case (pick)
        0: step("R1 mix", lfsr & 'h1FFF, ((lfsr >> 3) & 1) != 0 ? 'h0A : (lfsr >> 8), 1, 0);
        1: step("R2 mix", 'h2000 | (lfsr & 'h1FFF), lfsr >> 8, 1, 0);
        2: step("R3 mix", 'h4000 | (lfsr & 'h1FFF), lfsr >> 8, 1, 0);
        3: step("R10 mix", 'h6000 | (lfsr & 'h1FFF), lfsr >> 8, 1, 0);
        4: step("R9 mix", 'hA000 | (lfsr & 'h1FFF), lfsr >> 8, 1, 0);
        5: step("R6 mix", 'hA000 | (lfsr & 'h1FFF), 0, 0, 1);
        6: step("R5 mix", 'h4000 | (lfsr & 'h3FFF), 0, 0, 1);
        default: step("R4 mix", lfsr & 'h3FFF, 0, 0, 1);
      endcase
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule